// File: doc/BRIEF.md
# Clear-and-Sense Word Memory with Automatic Write-Back

This block holds a word-organised store whose read is destructive. Sensing a word drives every one of its bits to the zero state. A bit that held a one produces a per-bit "flipped" pulse as it falls, and a bit that already held zero produces nothing. The block rebuilds the word from those pulses and returns it to the host. It then writes the recovered word back into the same location before it accepts any further request.

The host side uses one request strobe with a direction bit, an address and write data. A ready output is high only while the block is idle. A read takes three clock phases: acceptance, clear-and-sense, and restore. The read data appears with a single-cycle valid pulse during the restore phase. A write takes two phases: acceptance and a single write phase that drives every bit of the word to its requested polarity. Any request made while ready is low is dropped.

Top module: `clrsense_mem`

## Requirements
- R1: After reset, `rdy` is 1, `rd_valid` is 0, and every word of the store reads back as zero.
- R2: A read is taken when `req`=1, `req_we`=0 and `rdy`=1 at a rising edge. `rdy` is then 0 for exactly two cycles and returns to 1 in the third cycle.
- R3: A write is taken when `req`=1, `req_we`=1 and `rdy`=1 at a rising edge. `rdy` is then 0 for exactly one cycle. The addressed word then holds `req_wdata`.
- R4: For a read, `rd_valid` is 1 for exactly one cycle, the second cycle after acceptance. In that cycle `rd_data` equals the word stored before the read.
- R5: Each bit of `rd_data` is 1 exactly when that stored bit flipped from 1 to 0 during sensing. Stored zeros return 0 and stored ones return 1, for any mix of bits.
- R6: During the restore cycle the addressed word holds all zeros. From the cycle after it, the word again holds the sensed value. A second read of the same address returns the same value.
- R7: Requests issued back to back, as soon as `rdy` rises, are each served in order. A write that follows a read, or a read that follows a write, sees the result of the earlier operation.
- R8: A request of either kind made while `rdy` is 0 has no effect on any stored word and starts no operation.
- R9: Address 0 and address DEPTH-1 are reached and stored independently of their neighbours.
- R10: A write of zeros over a word of ones leaves zeros. A write of ones over zeros leaves ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request strobe, taken only when `rdy` is 1 |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | $clog2(DEPTH) | Word address |
| req_wdata | input | WIDTH | Data for a write |
| rdy | output | 1 | High only while the block is idle |
| rd_valid | output | 1 | One-cycle pulse that marks read data |
| rd_data | output | WIDTH | Sensed word; held until the next read |

## Verification
The bench builds the block with its default 40-bit width and 16-word depth. This makes every address reachable, including both ends of the array. A single one and a single zero can also be walked across all 40 bit positions of one word. Repeated reads of the same address, mixed with writes of opposite polarity, expose any loss in the clear-and-restore path. The bench also holds a conflicting request across the busy phases to show that it is dropped.

// File: rtl/clrsense_pkg.sv
package clrsense_pkg;

  typedef enum logic [1:0] {
    ST_IDLE        = 2'd0,
    ST_CLEAR_SENSE = 2'd1,
    ST_RESTORE     = 2'd2,
    ST_WRITE       = 2'd3
  } phase_t;

  // Phase sequence: read = IDLE, CLEAR_SENSE, RESTORE, IDLE; write = IDLE, WRITE, IDLE
  function automatic phase_t phase_after(input phase_t cur, input logic take, input logic is_wr);
    phase_t nxt;
    case (cur)
      ST_IDLE:        nxt = take ? (is_wr ? ST_WRITE : ST_CLEAR_SENSE) : ST_IDLE;
      ST_CLEAR_SENSE: nxt = ST_RESTORE;
      ST_RESTORE:     nxt = ST_IDLE;
      default:        nxt = ST_IDLE;
    endcase
    return nxt;
  endfunction

  function automatic logic phase_drives_cells(input phase_t cur);
    return (cur == ST_RESTORE) || (cur == ST_WRITE);
  endfunction

endpackage

// File: rtl/clrsense_array.sv
module clrsense_array #(
  parameter int W  = 40,
  parameter int D  = 16,
  parameter int AW = $clog2(D)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  flip,
  output logic [W-1:0]  probe
);

  logic [W-1:0] rows [D];

  for (genvar r = 0; r < D; r++) begin : g_row
    logic         hit;
    logic [W-1:0] row_q;
    assign hit = (addr == AW'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              row_q <= '0;
      else if (wr_en && hit)   row_q <= wdata;
      else if (clr_en && hit)  row_q <= '0;
    end
    assign rows[r] = row_q;
  end

  // A cell that held 1 flips on clear; a cell that held 0 gives no pulse
  assign probe = rows[addr];
  assign flip  = clr_en ? probe : '0;

endmodule

// File: rtl/clrsense_sense.sv
module clrsense_sense #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-1:0] pulse,
  output logic [W-1:0] data_q,
  output logic         valid_q
);

  function automatic logic [W-1:0] rebuild(input logic [W-1:0] p);
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[i] = p[i] ? 1'b1 : 1'b0;
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= capture;
      if (capture) data_q <= rebuild(pulse);
    end
  end

endmodule

// File: rtl/clrsense_seq.sv
module clrsense_seq
  import clrsense_pkg::*;
#(
  parameter int W  = 40,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [W-1:0]  req_wdata,
  input  logic [W-1:0]  sensed,
  output logic          rdy,
  output logic          clr_en,
  output logic          wr_en,
  output logic [AW-1:0] cur_addr,
  output logic [W-1:0]  wr_data,
  output phase_t        phase
);

  phase_t        phase_q;
  logic [AW-1:0] addr_q;
  logic [W-1:0]  wdata_q;
  logic          take;

  assign take = req && (phase_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      phase_q <= phase_after(phase_q, take, req_we);
      if (take) begin
        addr_q <= req_addr;
        if (req_we) wdata_q <= req_wdata;
      end
    end
  end

  assign rdy      = (phase_q == ST_IDLE);
  assign clr_en   = (phase_q == ST_CLEAR_SENSE);
  assign wr_en    = phase_drives_cells(phase_q);
  assign wr_data  = (phase_q == ST_RESTORE) ? sensed : wdata_q;
  assign cur_addr = addr_q;
  assign phase    = phase_q;

endmodule

// File: rtl/clrsense_mem.sv
module clrsense_mem
  import clrsense_pkg::*;
#(
  parameter int WIDTH = 40,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_we,
  input  logic [AW-1:0]    req_addr,
  input  logic [WIDTH-1:0] req_wdata,
  output logic             rdy,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data
);

  phase_t           phase;
  logic             clr_en;
  logic             wr_en;
  logic [AW-1:0]    cur_addr;
  logic [WIDTH-1:0] wr_data;
  logic [WIDTH-1:0] flip;
  logic [WIDTH-1:0] word_at_addr;

  clrsense_seq #(.W(WIDTH), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .sensed(rd_data),
    .rdy(rdy), .clr_en(clr_en), .wr_en(wr_en), .cur_addr(cur_addr),
    .wr_data(wr_data), .phase(phase)
  );

  clrsense_array #(.W(WIDTH), .D(DEPTH), .AW(AW)) u_array (
    .clk(clk), .rst_n(rst_n), .clr_en(clr_en), .wr_en(wr_en),
    .addr(cur_addr), .wdata(wr_data), .flip(flip), .probe(word_at_addr)
  );

  clrsense_sense #(.W(WIDTH)) u_sense (
    .clk(clk), .rst_n(rst_n), .capture(clr_en), .pulse(flip),
    .data_q(rd_data), .valid_q(rd_valid)
  );

endmodule

// File: rtl/clrsense_chk.sv
module clrsense_chk
  import clrsense_pkg::*;
#(
  parameter int W  = 40,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          req_we,
  input logic          rdy,
  input logic          rd_valid,
  input logic [W-1:0]  rd_data,
  input phase_t        phase,
  input logic [AW-1:0] cur_addr,
  input logic [W-1:0]  word_at_addr
);

  assert_read_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && req && !req_we) |=> !rdy ##1 !rdy ##1 rdy);

  assert_write_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && req && req_we) |=> !rdy ##1 rdy);

  assert_valid_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && req && !req_we) |=> !rd_valid ##1 rd_valid);

  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_valid_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !rdy);

  assert_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_RESTORE) |-> (word_at_addr == '0));

  assert_restored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_RESTORE) |=> (word_at_addr == $past(rd_data)));

  // Host side: a request while not ready is dropped and must not retarget the operation
  assert_dropped_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !rdy) |=> $stable(cur_addr));

endmodule

bind clrsense_mem clrsense_chk #(.W(WIDTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .rdy(rdy),
  .rd_valid(rd_valid), .rd_data(rd_data), .phase(phase),
  .cur_addr(cur_addr), .word_at_addr(word_at_addr)
);

// File: tb/test_clrsense_mem.sv
module test_clrsense_mem;

  localparam int W  = 40;
  localparam int D  = 16;
  localparam int AW = $clog2(D);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [W-1:0]  req_wdata = '0;
  logic          rdy;
  logic          rd_valid;
  logic [W-1:0]  rd_data;

  logic [W-1:0]  shadow [D];
  int            n_checks = 0;
  int            n_errors = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  clrsense_mem #(.WIDTH(W), .DEPTH(D)) i_clrsense_mem (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rdy(rdy), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    check(rdy === 1'b1, "R3 ready before write", 64'(rdy), 64'd1);
    req = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 1'b0;
    check(rdy === 1'b0, "R3 busy during write", 64'(rdy), 64'd0);
    @(negedge clk);
    check(rdy === 1'b1, "R3 ready after one busy cycle", 64'(rdy), 64'd1);
    shadow[a] = d;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    req = 1'b1; req_we = 1'b0; req_addr = a;
    @(negedge clk);
    req = 1'b0;
    check(rdy === 1'b0 && rd_valid === 1'b0, "R2 clear-sense cycle busy, no valid",
          64'({rdy, rd_valid}), 64'd0);
    @(negedge clk);
    check(rd_valid === 1'b1, "R4 valid in restore cycle", 64'(rd_valid), 64'd1);
    check(rd_data === shadow[a], tag, 64'(rd_data), 64'(shadow[a]));
    check(rdy === 1'b0, "R2 restore cycle busy", 64'(rdy), 64'd0);
    @(negedge clk);
    check(rdy === 1'b1 && rd_valid === 1'b0, "R2 R4 idle after read, valid dropped",
          64'({rdy, rd_valid}), 64'd2);
  endtask

  task automatic t_reset;
    check(rdy === 1'b1, "R1 rdy after reset", 64'(rdy), 64'd1);
    check(rd_valid === 1'b0, "R1 rd_valid after reset", 64'(rd_valid), 64'd0);
    for (int a = 0; a < D; a++) do_read(AW'(a), "R1 word zero after reset");
  endtask

  task automatic t_patterns;
    do_write(4'd3, {W{1'b1}});
    do_read(4'd3, "R5 all ones");
    do_write(4'd4, 40'hAA_AAAA_AAAA);
    do_read(4'd4, "R5 alternating AA");
    do_write(4'd4, 40'h55_5555_5555);
    do_read(4'd4, "R5 alternating 55");
    do_write(4'd7, 40'h12_3456_789A);
    do_read(4'd7, "R4 mixed pattern");
  endtask

  task automatic t_reread;
    do_write(4'd9, 40'hC3_0F5A_E1B7);
    do_read(4'd9, "R6 first read");
    do_read(4'd9, "R6 second read same value");
    do_read(4'd9, "R6 third read same value");
  endtask

  task automatic t_walk;
    for (int b = 0; b < W; b++) begin
      do_write(4'd5, W'(1) << b);
      do_read(4'd5, "R5 walking one");
      do_write(4'd5, ~(W'(1) << b));
      do_read(4'd5, "R5 walking zero");
    end
  endtask

  task automatic t_bounds;
    do_write(AW'(0), 40'hFF_0000_00FF);
    do_write(AW'(D-1), 40'h00_FFFF_FF00);
    do_write(AW'(1), 40'h0F_0F0F_0F0F);
    do_read(AW'(0), "R9 address zero");
    do_read(AW'(D-1), "R9 top address");
    do_read(AW'(1), "R9 neighbour of zero");
  endtask

  task automatic t_overwrite;
    do_write(4'd11, {W{1'b1}});
    do_write(4'd11, {W{1'b0}});
    do_read(4'd11, "R10 zeros over ones");
    do_write(4'd11, {W{1'b1}});
    do_read(4'd11, "R10 ones over zeros");
  endtask

  task automatic t_back_to_back;
    do_write(4'd12, 40'h01_2345_6789);
    do_read(4'd12, "R7 read right after write");
    do_write(4'd12, 40'hFE_DCBA_9876);
    do_read(4'd12, "R7 write right after read");
    do_read(4'd13, "R7 other address untouched");
  endtask

  task automatic t_ignored;
    do_write(4'd2, 40'h11_2233_4455);
    do_write(4'd6, 40'h66_7788_99AA);
    @(negedge clk);
    req = 1'b1; req_we = 1'b0; req_addr = 4'd2;
    @(negedge clk);
    // busy now: hold a conflicting write request through both busy cycles
    req = 1'b1; req_we = 1'b1; req_addr = 4'd6; req_wdata = 40'hDE_ADBE_EF00;
    @(negedge clk);
    check(rd_valid === 1'b1 && rd_data === shadow[2], "R8 read unaffected by dropped request",
          64'(rd_data), 64'(shadow[2]));
    @(negedge clk);
    req = 1'b0;
    check(rdy === 1'b1, "R8 no operation started by dropped request", 64'(rdy), 64'd1);
    @(negedge clk);
    check(rdy === 1'b1, "R8 still idle", 64'(rdy), 64'd1);
    do_read(4'd6, "R8 target of dropped write unchanged");
    do_read(4'd2, "R8 read word restored");
  endtask

  initial begin
    for (int a = 0; a < D; a++) shadow[a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_patterns();
    t_reread();
    t_walk();
    t_bounds();
    t_overwrite();
    t_back_to_back();
    t_ignored();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule